// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns an interrupt's addressing fields into the set of local interrupt controllers that must receive it. A request carries a destination byte, a bit that picks physical or logical addressing, a two-bit shorthand and the index of the sending controller. The block resolves these against a small configuration table that holds, for each of `N_CTRL` controllers, an identifier byte, a logical destination byte and a four-bit destination model. The result is a bitmask with one bit per controller, where bit i set means controller i is a target.

Logical addressing supports two layouts. In the flat model the destination byte is treated as a set of group bits. In the cluster model the upper nibble names a cluster and the lower nibble a set of members inside it. When a request asks for lowest-priority delivery, the resolved mask is narrowed to a single target, which is the lowest-indexed set bit.

Requests enter through a valid/ready port and responses leave through a registered valid/ready port. The block accepts a request only when its single output slot is empty or is being drained in the same cycle. A stalled response stays unchanged until the consumer takes it. Table writes use a plain indexed write strobe.

Top module: `idr_top`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1. Each table entry i holds identifier i, logical byte 0x00 and destination model 0xF.
- R2: A table write (cfg_we=1) to entry cfg_idx takes effect from the next clock edge. cfg_field 0 loads the identifier from cfg_wdata[7:0]. Field 1 loads the logical byte from cfg_wdata[31:24]. Field 2 loads the model from cfg_wdata[31:28]. Field 3 changes nothing.
- R3: With shorthand 1 the mask is only the sender's bit (req_self). With shorthand 2 it is every controller. With shorthand 3 it is every controller except the sender. With shorthand 0 the mask comes from the destination rules in R4 to R6.
- R4: With physical addressing (req_logical=0), destination 0xFF selects every controller. Any other destination selects only the lowest-indexed controller whose identifier equals it, or no controller if none does.
- R5: With logical addressing, a controller whose model is 0xF matches when the destination AND its logical byte is nonzero.
- R6: With logical addressing, a controller whose model is 0x0 matches when the upper nibbles of the destination and the logical byte are equal and the AND of their lower nibbles is nonzero. A controller with any other model never matches.
- R7: When req_lowpri=1, the response holds only the lowest-indexed set bit of the resolved mask. An empty resolved mask stays empty.
- R8: An accepted request whose resolved mask is empty still yields a valid response with rsp_mask all zero.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both 1. Its response appears on the next cycle. req_ready is 1 exactly when rsp_valid is 0 or rsp_ready is 1. While rsp_valid=1 and rsp_ready=0, rsp_valid and rsp_mask hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_field | input | 2 | Field select: 0 identifier, 1 logical byte, 2 model, 3 none |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | Destination shorthand |
| req_lowpri | input | 1 | Narrow to one target |
| req_self | input | IDX_W | Sender's index |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_mask | output | N_CTRL | Target bitmask |

## Verification
On every cycle, the assertions check the back-pressure rules. A stalled response must hold, ready must drop while stalled, and an accepted request must produce a response. They also check the shorthand results that follow from the request alone: sender-only, and exclusion of the sender. They further check that a lowest-priority response has at most one bit set. The rules that depend on table contents can only be shown by the bench's scenarios. These are physical identifier matching with its lowest-index choice, flat and cluster logical matching, ignored models, and the field positions of table writes. For these, the bench tracks its own copy of the table and predicts each mask.

// File: rtl/idr_pkg.sv
package idr_pkg;
  localparam int BYTE_W  = 8;
  localparam int MODEL_W = 4;

  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
  localparam logic [BYTE_W-1:0]  DEST_ALL      = 8'hFF;

  typedef enum logic [1:0] {
    SH_NONE     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_ALL_BUT  = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    FLD_ID    = 2'd0,
    FLD_LOGB  = 2'd1,
    FLD_MODEL = 2'd2,
    FLD_NONE  = 2'd3
  } cfg_field_e;

  typedef struct packed {
    logic [BYTE_W-1:0]  id;
    logic [BYTE_W-1:0]  logb;
    logic [MODEL_W-1:0] model;
  } ctrl_cfg_t;
endpackage

// File: rtl/idr_pick_first.sv
module idr_pick_first #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec_in,
  output logic [WIDTH-1:0] vec_out
);
  // Isolate the lowest set bit: two's complement trick.
  logic [WIDTH-1:0] neg;
  assign neg     = (~vec_in) + {{(WIDTH-1){1'b0}}, 1'b1};
  assign vec_out = vec_in & neg;
endmodule

// File: rtl/idr_cfg_table.sv
module idr_cfg_table
  import idr_pkg::*;
#(
  parameter int N_CTRL = 8,
  parameter int IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [1:0]            cfg_field,
  input  logic [31:0]           cfg_wdata,
  output ctrl_cfg_t [N_CTRL-1:0] table_q
);
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[23:8];

  for (genvar i = 0; i < N_CTRL; i++) begin : g_entry
    logic hit;
    assign hit = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        table_q[i].id    <= BYTE_W'(i);
        table_q[i].logb  <= '0;
        table_q[i].model <= MODEL_FLAT;
      end else if (hit) begin
        case (cfg_field_e'(cfg_field))
          FLD_ID:    table_q[i].id    <= cfg_wdata[7:0];
          FLD_LOGB:  table_q[i].logb  <= cfg_wdata[31:24];
          FLD_MODEL: table_q[i].model <= cfg_wdata[31:28];
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idr_match.sv
module idr_match
  import idr_pkg::*;
#(
  parameter int N_CTRL = 8,
  parameter int IDX_W  = 3
) (
  input  ctrl_cfg_t [N_CTRL-1:0] table_q,
  input  logic [BYTE_W-1:0]      dest,
  input  logic                   logical,
  input  logic [1:0]             shorthand,
  input  logic                   lowpri,
  input  logic [IDX_W-1:0]       self_idx,
  output logic [N_CTRL-1:0]      mask
);
  logic [N_CTRL-1:0] id_hit, log_hit, id_first, phys_mask;
  logic [N_CTRL-1:0] dest_mask, self_oh, sh_mask, narrowed;

  for (genvar i = 0; i < N_CTRL; i++) begin : g_cmp
    logic flat_m, clus_m;
    assign id_hit[i] = (table_q[i].id == dest);
    assign flat_m = (table_q[i].model == MODEL_FLAT) &&
                    (|(dest & table_q[i].logb));
    assign clus_m = (table_q[i].model == MODEL_CLUSTER) &&
                    (dest[7:4] == table_q[i].logb[7:4]) &&
                    (|(dest[3:0] & table_q[i].logb[3:0]));
    assign log_hit[i] = flat_m | clus_m;
    assign self_oh[i] = (self_idx == IDX_W'(i));
  end

  idr_pick_first #(.WIDTH(N_CTRL)) u_id_first (
    .vec_in  (id_hit),
    .vec_out (id_first)
  );

  assign phys_mask = (dest == DEST_ALL) ? {N_CTRL{1'b1}} : id_first;
  assign dest_mask = logical ? log_hit : phys_mask;

  always_comb begin
    case (shorthand_e'(shorthand))
      SH_SELF:    sh_mask = self_oh;
      SH_ALL:     sh_mask = {N_CTRL{1'b1}};
      SH_ALL_BUT: sh_mask = ~self_oh;
      default:    sh_mask = dest_mask;
    endcase
  end

  idr_pick_first #(.WIDTH(N_CTRL)) u_lowpri (
    .vec_in  (sh_mask),
    .vec_out (narrowed)
  );

  assign mask = lowpri ? narrowed : sh_mask;
endmodule

// File: rtl/idr_top.sv
module idr_top
  import idr_pkg::*;
#(
  parameter int N_CTRL = 8,
  parameter int IDX_W  = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_field,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_dest,
  input  logic              req_logical,
  input  logic [1:0]        req_shorthand,
  input  logic              req_lowpri,
  input  logic [IDX_W-1:0]  req_self,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [N_CTRL-1:0] rsp_mask
);
  ctrl_cfg_t [N_CTRL-1:0] table_q;
  logic [N_CTRL-1:0]      mask_d;
  logic                   take;

  idr_cfg_table #(.N_CTRL(N_CTRL), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .table_q   (table_q)
  );

  idr_match #(.N_CTRL(N_CTRL), .IDX_W(IDX_W)) u_match (
    .table_q   (table_q),
    .dest      (req_dest),
    .logical   (req_logical),
    .shorthand (req_shorthand),
    .lowpri    (req_lowpri),
    .self_idx  (req_self),
    .mask      (mask_d)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_mask  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_mask  <= mask_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
  parameter int N_CTRL = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_shorthand,
  input logic              req_lowpri,
  input logic [IDX_W-1:0]  req_self,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [N_CTRL-1:0] rsp_mask
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask))); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R9

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R8

  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_shorthand == 2'd1)
      |=> (rsp_mask == (N_CTRL'(1) << $past(req_self)))); // R3

  AST_SENDER_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_shorthand == 2'd3)
      |=> !rsp_mask[$past(req_self)]); // R3

  AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_lowpri) |=> $onehot0(rsp_mask)); // R7
endmodule

bind idr_top idr_checker #(.N_CTRL(N_CTRL), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_shorthand (req_shorthand),
  .req_lowpri    (req_lowpri),
  .req_self      (req_self),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_mask      (rsp_mask)
);

// File: tb/idr_top_test.sv
`timescale 1ns/1ps
module idr_top_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [IW-1:0] cfg_idx = 0; logic [1:0] cfg_field = 0;
  logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_ready, req_logical = 0, req_lowpri = 0;
  logic [7:0] req_dest = 0; logic [1:0] req_shorthand = 0;
  logic [IW-1:0] req_self = 0;
  logic rsp_valid, rsp_ready = 1;
  logic [N-1:0] rsp_mask;

  int checks = 0, errors = 0;
  logic [7:0] m_id [N];
  logic [7:0] m_log [N];
  logic [3:0] m_mdl [N];

  always #10 clk = ~clk;

  idr_top #(.N_CTRL(N)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] first_bit(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [N-1:0] expect_mask(logic [7:0] d, logic lg,
      logic [1:0] sh, logic lp, logic [IW-1:0] s);
    logic [N-1:0] m = '0;
    case (sh)
      2'd1: m = N'(1) << s;
      2'd2: m = '1;
      2'd3: m = ~(N'(1) << s);
      default: begin
        if (!lg) begin
          if (d == 8'hFF) m = '1;
          else begin
            for (int i = N-1; i >= 0; i--) if (m_id[i] == d) m = N'(1) << i;
          end
        end else begin
          for (int i = 0; i < N; i++) begin
            if (m_mdl[i] == 4'hF && (d & m_log[i]) != 0) m[i] = 1'b1;
            if (m_mdl[i] == 4'h0 && d[7:4] == m_log[i][7:4] &&
                (d[3:0] & m_log[i][3:0]) != 0) m[i] = 1'b1;
          end
        end
      end
    endcase
    return lp ? first_bit(m) : m;
  endfunction

  task automatic wr(int idx, logic [1:0] f, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_field = f; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (f == 2'd0) m_id[idx] = v[7:0];
    else if (f == 2'd1) m_log[idx] = v[31:24];
    else if (f == 2'd2) m_mdl[idx] = v[31:28];
  endtask

  task automatic send(string req, logic [7:0] d, logic lg, logic [1:0] sh,
      logic lp, logic [IW-1:0] s);
    logic [N-1:0] e;
    e = expect_mask(d, lg, sh, lp, s);
    @(negedge clk);
    req_valid = 1; req_dest = d; req_logical = lg; req_shorthand = sh;
    req_lowpri = lp; req_self = s;
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check(req, 32'(rsp_mask), 32'(e));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_id[i] = 8'(i); m_log[i] = 8'h00; m_mdl[i] = 4'hF;
    end
    repeat (3) @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    rst_n = 1;
    // R1: reset identifiers equal index
    send("R1 R4 reset id", 8'd5, 0, 0, 0, 0);
    send("R1 R5 reset logb zero", 8'hFF, 1, 0, 0, 0);
    // R3 shorthands
    send("R3 self", 8'h00, 0, 1, 0, 3'd6);
    send("R3 all", 8'h00, 0, 2, 0, 3'd2);
    send("R3 all but", 8'h00, 1, 3, 0, 3'd0);
    // R4 physical
    send("R4 broadcast", 8'hFF, 0, 0, 0, 0);
    send("R4 no match", 8'h40, 0, 0, 0, 0);
    wr(6, 2'd0, 32'hABCD_0003);
    send("R2 R4 duplicate id lowest", 8'h03, 0, 0, 0, 0);
    send("R2 R4 moved id", 8'h06, 0, 0, 0, 0);
    // R5/R6 logical
    wr(1, 2'd1, 32'h0300_00FF);
    wr(2, 2'd1, 32'h2500_0000);
    wr(2, 2'd2, 32'h0FFF_FFFF);
    wr(4, 2'd1, 32'h2A00_0000);
    wr(4, 2'd2, 32'h0000_0000);
    wr(5, 2'd1, 32'hFF00_0000);
    wr(5, 2'd2, 32'h7000_0000);
    wr(7, 2'd3, 32'hFFFF_FFFF);
    send("R5 flat", 8'h01, 1, 0, 0, 0);
    send("R6 cluster", 8'h21, 1, 0, 0, 0);
    send("R6 cluster nibble miss", 8'h24, 1, 0, 0, 0);
    send("R6 other model ignored", 8'hFF, 1, 0, 0, 0);
    send("R2 field3 ignored", 8'h07, 0, 0, 0, 0);
    // R7/R8
    send("R7 lowpri", 8'h00, 0, 3, 1, 3'd0);
    send("R7 R8 lowpri empty", 8'h80, 1, 0, 1, 0);
    send("R8 empty", 8'h55, 0, 0, 0, 0);
    // R9 back-pressure
    begin
      logic [N-1:0] ea, eb;
      ea = expect_mask(8'h00, 0, 1, 0, 3'd1);
      eb = expect_mask(8'h00, 0, 1, 0, 3'd4);
      @(negedge clk);
      rsp_ready = 0; req_valid = 1; req_shorthand = 1; req_self = 3'd1;
      req_lowpri = 0;
      @(negedge clk);
      req_self = 3'd4;
      check("R9 stalled ready", 32'(req_ready), 0);
      @(negedge clk);
      check("R9 hold valid", 32'(rsp_valid), 1);
      check("R9 hold mask", 32'(rsp_mask), 32'(ea));
      rsp_ready = 1;
      @(negedge clk);
      req_valid = 0;
      check("R9 next mask", 32'(rsp_mask), 32'(eb));
      @(negedge clk);
      check("R9 drained", 32'(rsp_valid), 0);
    end
    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 4 == 0)
        wr($urandom % N, 2'($urandom % 4), {$urandom % 2 ? 4'h0 : 4'hF,
           4'($urandom), 16'($urandom), 4'h0, 4'($urandom % 8)});
      send("R3 R4 R5 R6 R7 random", ($urandom % 3 == 0) ? 8'hFF : 8'($urandom),
           1'($urandom), 2'($urandom % 5 == 0 ? $urandom : 0),
           1'($urandom), IW'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule